// File: doc/BRIEF.md
# Reconfigurable Sum-of-Products Output Cell

This block is one output slice of a reprogrammable array-logic device. A bank of fuse rows, one per product term, chooses which true and complemented inputs each AND term takes in. A fixed OR gate sums the terms. An output stage then selects combinational or registered operation, applies an exclusive-OR polarity stage, and controls the pin driver. With the driver off, the pin works as an input.

The pin is modelled as a value and an output-enable pair, with a separate pad-level input. The feedback output carries what the array at the next level should see. That is the driven pin level when the driver is on, and the pad level when the cell is used as an input. Configuration is written through a strobed address/data port, one fuse row or the mode word per clock.

Top module: `sop_macrocell`

## Requirements
- R1: Fuse row bit i (0 to NUM_IN-1) set to 1 includes input i in true form. Bit NUM_IN+i set to 1 includes input i in complemented form. A term is the AND of all its included literals.
- R2: A term whose row holds no 1 bit evaluates to 0.
- R3: The sum is the OR of all product terms.
- R4: With mode bit S1=1 the pin follows the sum in the same cycle. Mode bit S0=1 leaves it non-inverted and S0=0 inverts it.
- R5: With S1=0 a flip-flop captures the sum on every rising clock edge. The pin shows the flop value, inverted when S0=0. Input changes between edges do not reach the pin.
- R6: When cfgLoad=1, a write to address t (0 to NUM_TERMS-1) replaces fuse row t at the clock edge. When cfgLoad=0, no configuration changes.
- R7: A write to address NUM_TERMS loads the mode word: data bit 0 is S0, bit 1 is S1, bit 2 is the driver enable.
- R8: With the driver enable at 0, pinOe is 0 and fbOut equals pinIn. With the enable at 1, pinOe is 1 and fbOut equals pinOut.
- R9: A synchronous reset clears all fuse rows and the flop to 0. It sets S1=1 and S0=1 with the driver disabled.
- R10: Writes to addresses above NUM_TERMS change nothing.

Ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgLoad | input | 1 | Configuration write strobe |
| cfgAddr | input | $clog2(NUM_TERMS+1) | Row index, or NUM_TERMS for the mode word |
| cfgData | input | 2*NUM_IN | Fuse row or mode word |
| inBus | input | NUM_IN | Array inputs |
| pinIn | input | 1 | Level seen on the pad |
| pinOut | output | 1 | Value driven toward the pad |
| pinOe | output | 1 | Pad driver enable |
| fbOut | output | 1 | Feedback toward the array |

## Verification
The assertions assume a stable, known pinIn whenever the driver is off. They also assume that reset is held high for at least one edge before any other activity. The bench drives every input on the falling edge and holds pinIn at a defined level at all times. It asserts reset for several edges at start-up and again mid-run. The registered-path assertion compares against the sum from the previous cycle, so the bench changes inputs only away from the rising edge.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;
  localparam int MODE_W = 3;
  localparam int MODE_S0_BIT = 0;
  localparam int MODE_S1_BIT = 1;
  localparam int MODE_OE_BIT = 2;

  typedef struct packed {
    logic regMode;
    logic invert;
    logic drive;
  } cellCtrl_t;
endpackage

// File: rtl/sop_cell_ctrl.sv
module sop_cell_ctrl
  import sop_cell_pkg::*;
#(
  parameter int NUM_TERMS = 8,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgLoad,
  input  logic [AW-1:0]        cfgAddr,
  input  logic [DW-1:0]        cfgData,
  output logic [NUM_TERMS-1:0] rowWe,
  output cellCtrl_t            cellCtrl
);
  localparam logic [AW-1:0] MODE_ADDR = AW'(NUM_TERMS);

  logic modeS0, modeS1, modeOe;
  logic modeWe;

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_rowDec
    assign rowWe[t] = cfgLoad && (cfgAddr == AW'(t));
  end

  assign modeWe = cfgLoad && (cfgAddr == MODE_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeS0 <= 1'b1;
      modeS1 <= 1'b1;
      modeOe <= 1'b0;
    end else if (modeWe) begin
      modeS0 <= cfgData[MODE_S0_BIT];
      modeS1 <= cfgData[MODE_S1_BIT];
      modeOe <= cfgData[MODE_OE_BIT];
    end
  end

  assign cellCtrl.regMode = ~modeS1;
  assign cellCtrl.invert  = ~modeS0;
  assign cellCtrl.drive   = modeOe;

  // R6: at most one fuse row written per cycle
  p_row_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rowWe));

  // R10: out-of-range address leaves the mode untouched
  p_bad_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (cfgLoad && (cfgAddr > MODE_ADDR)) |=> $stable(cellCtrl));

  // R9: mode defaults right after reset
  p_reset_mode_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cellCtrl.regMode && !cellCtrl.invert && !cellCtrl.drive));
endmodule

// File: rtl/sop_cell_dp.sv
module sop_cell_dp
  import sop_cell_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_TERMS = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TERMS-1:0] rowWe,
  input  logic [DW-1:0]        cfgData,
  input  cellCtrl_t            cellCtrl,
  input  logic [NUM_IN-1:0]    inBus,
  input  logic                 pinIn,
  output logic                 pinOut,
  output logic                 pinOe,
  output logic                 fbOut
);
  logic [DW-1:0]        literals;
  logic [NUM_TERMS-1:0] termHit;
  logic                 sumOut;
  logic                 regQ;
  logic                 level;

  assign literals = {~inBus, inBus};

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [DW-1:0] fuseRow;
    always_ff @(posedge clk) begin
      if (rst)           fuseRow <= '0;
      else if (rowWe[t]) fuseRow <= cfgData;
    end
    assign termHit[t] = (|fuseRow) & (&(~fuseRow | literals));
  end

  assign sumOut = |termHit;

  always_ff @(posedge clk) begin
    if (rst) regQ <= 1'b0;
    else     regQ <= sumOut;
  end

  assign level  = cellCtrl.regMode ? regQ : sumOut;
  assign pinOut = level ^ cellCtrl.invert;
  assign pinOe  = cellCtrl.drive;
  assign fbOut  = cellCtrl.drive ? pinOut : pinIn;

  // R5: registered pin reflects the sum one edge earlier
  p_reg_path_r5: assert property (@(posedge clk) disable iff (rst)
    (cellCtrl.regMode && !$past(rst)) |-> (pinOut == ($past(sumOut) ^ cellCtrl.invert)));

  // R8: input-only use passes the pad level back
  p_hiz_fb_r8: assert property (@(posedge clk) disable iff (rst)
    !pinOe |-> (fbOut == pinIn));

  // R8: driven use feeds back the driven value
  p_drive_fb_r8: assert property (@(posedge clk) disable iff (rst)
    pinOe |-> (fbOut == pinOut));

  // R9: flop cleared by reset
  p_flop_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (regQ == 1'b0));
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import sop_cell_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_TERMS = 8,
  localparam int DW = 2 * NUM_IN,
  localparam int AW = $clog2(NUM_TERMS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfgLoad,
  input  logic [AW-1:0] cfgAddr,
  input  logic [DW-1:0] cfgData,
  input  logic [NUM_IN-1:0] inBus,
  input  logic          pinIn,
  output logic          pinOut,
  output logic          pinOe,
  output logic          fbOut
);
  logic [NUM_TERMS-1:0] rowWe;
  cellCtrl_t            cellCtrl;

  sop_cell_ctrl #(.NUM_TERMS(NUM_TERMS), .AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .rowWe(rowWe), .cellCtrl(cellCtrl)
  );

  sop_cell_dp #(.NUM_IN(NUM_IN), .NUM_TERMS(NUM_TERMS), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .rowWe(rowWe), .cfgData(cfgData),
    .cellCtrl(cellCtrl), .inBus(inBus), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );
endmodule

// File: tb/sim_sop_macrocell.sv
`timescale 1ns/1ps
module sim_sop_macrocell;
  localparam int NI = 8;
  localparam int NT = 8;
  localparam int DW = 2 * NI;
  localparam int AW = $clog2(NT + 1);

  logic clk = 1'b0;
  logic rst;
  logic cfgLoad;
  logic [AW-1:0] cfgAddr;
  logic [DW-1:0] cfgData;
  logic [NI-1:0] inBus;
  logic pinIn;
  logic pinOut, pinOe, fbOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sop_macrocell #(.NUM_IN(NI), .NUM_TERMS(NT)) u0 (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .inBus(inBus), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    cfgLoad = 1'b1; cfgAddr = AW'(addr); cfgData = data;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic apply(input logic [NI-1:0] v);
    inBus = v;
    #1;
  endtask

  task automatic tReset();
    pinIn = 1'b1; #1;
    check("R9 oe off", pinOe, 1'b0);
    check("R8 fb pad high", fbOut, 1'b1);
    pinIn = 1'b0; #1;
    check("R8 fb pad low", fbOut, 1'b0);
    cfgWrite(NT, 16'h0007);
    check("R7 drive on", pinOe, 1'b1);
    apply(8'hFF);
    check("R2 R9 blank rows", pinOut, 1'b0);
    check("R8 fb driven", fbOut, 1'b0);
  endtask

  task automatic tLiteral();
    cfgWrite(0, 16'h0201);
    apply(8'h01); check("R1 a&~b hit", pinOut, 1'b1);
    apply(8'h03); check("R1 b blocks", pinOut, 1'b0);
    apply(8'h00); check("R1 a missing", pinOut, 1'b0);
    apply(8'h02); check("R1 none", pinOut, 1'b0);
  endtask

  task automatic tOr();
    cfgWrite(1, 16'h0004);
    apply(8'h04); check("R3 term1", pinOut, 1'b1);
    apply(8'h05); check("R3 both", pinOut, 1'b1);
    apply(8'h01); check("R3 term0", pinOut, 1'b1);
    apply(8'h08); check("R3 neither", pinOut, 1'b0);
  endtask

  task automatic tPolarity();
    cfgWrite(NT, 16'h0006);
    apply(8'h01); check("R4 inverted hit", pinOut, 1'b0);
    apply(8'h00); check("R4 inverted miss", pinOut, 1'b1);
    cfgWrite(NT, 16'h0007);
    apply(8'h01); check("R4 true hit", pinOut, 1'b1);
  endtask

  task automatic tLoadGate();
    @(negedge clk);
    cfgLoad = 1'b0; cfgAddr = AW'(2); cfgData = 16'h0008;
    @(negedge clk);
    cfgAddr = AW'(NT); cfgData = 16'h0000;
    @(negedge clk);
    apply(8'h08); check("R6 row unchanged", pinOut, 1'b0);
    check("R6 mode unchanged", pinOe, 1'b1);
  endtask

  task automatic tBadAddr();
    cfgWrite(9, 16'h0010);
    cfgWrite(15, 16'h0000);
    apply(8'h10); check("R10 no row", pinOut, 1'b0);
    check("R10 oe kept", pinOe, 1'b1);
    apply(8'h01); check("R10 polarity kept", pinOut, 1'b1);
  endtask

  task automatic tRegistered();
    inBus = 8'h00;
    cfgWrite(NT, 16'h0005);
    @(negedge clk); #1;
    check("R5 idle low", pinOut, 1'b0);
    apply(8'h01); check("R5 hold before edge", pinOut, 1'b0);
    @(negedge clk); #1;
    check("R5 captured", pinOut, 1'b1);
    apply(8'h00); check("R5 hold high", pinOut, 1'b1);
    @(negedge clk); #1;
    check("R5 captured low", pinOut, 1'b0);
    cfgWrite(NT, 16'h0004); #1;
    check("R5 active-low idle", pinOut, 1'b1);
    apply(8'h01);
    @(negedge clk); #1;
    check("R5 active-low hit", pinOut, 1'b0);
  endtask

  task automatic tFeedback();
    cfgWrite(NT, 16'h0005); #1;
    check("R8 reg fb", fbOut, pinOut);
    cfgWrite(NT, 16'h0000);
    pinIn = 1'b1; #1;
    check("R8 input-only oe", pinOe, 1'b0);
    check("R8 input-only fb1", fbOut, 1'b1);
    pinIn = 1'b0; #1;
    check("R8 input-only fb0", fbOut, 1'b0);
  endtask

  task automatic tMidReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0; #1;
    check("R9 oe after reset", pinOe, 1'b0);
    cfgWrite(NT, 16'h0007);
    apply(8'h01); check("R9 rows cleared", pinOut, 1'b0);
  endtask

  initial begin
    rst = 1'b1; cfgLoad = 1'b0; cfgAddr = '0; cfgData = '0;
    inBus = '0; pinIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    tReset();
    tLiteral();
    tOr();
    tPolarity();
    tLoadGate();
    tBadAddr();
    tRegistered();
    tFeedback();
    tMidReset();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule